// File: doc/BRIEF.md
# Chainable Serial Configuration Memory Reader

This block is the read side of a serial configuration store that boots an SRAM-based FPGA. The contents are held as 32-bit words, and the number of words is set by a parameter. While the device is selected, each rising clock edge moves the output to the next bit. The bits leave each word starting with the most significant one, and the words go out in rising address order. A bit index and a word address, both held in registers, mark the current position in the array.

A single shared pin does two jobs: it resets the position and it enables the output. The polarity of this pin is not fixed. It is read from an extra word stored one location past the last data word. A select input gates both the counting and the output. When the last bit has been read, the block hands over to the next device through an active-low chain-select output. Several devices can therefore be chained, with each select output wired to the select input of the following device. The array image is written through a simple load port, and the bench uses that port to set the contents.

Top module: `sercfg_rom`

## Requirements
- R1: Once the position has been cleared, and while the device is selected with its output enabled, `data_oe` is 1 and `data_out` shows bit 31 of word 0. A word is written at a rising edge when `ld_we` is 1, and addresses 0 to WORDS are accepted.
- R2: Each rising edge that occurs while the device is selected and not resetting moves the output on by one bit. The order is bit 31 down to bit 0 of each word, and the address then goes to the next word.
- R3: `data_oe` is 1 only when `ce_n` is 0 and the shared pin is at its output-enable level. At all other times `data_oe` and `data_out` are both 0.
- R4: While `ce_n` is 1 and no reset is applied, clock edges do not move the position. After `ce_n` returns to 0, the output continues from the bit it had reached.
- R5: A rising edge taken while the shared pin is at its reset level returns the position to bit 31 of word 0, whether or not `ce_n` is asserted.
- R6: When the word at address WORDS is all zeros, a pin level of 0 means reset and a level of 1 means output enable. When that word is all ones, a level of 1 means reset and a level of 0 means output enable.
- R7: When the word at address WORDS holds any value other than all zeros or all ones, the pin resets on level 1 and enables the output on level 0.
- R8: The edge that consumes bit 0 of the last word ends the read. From then on the position holds, `data_oe` stays 0, and `ceo_n` is 0 while `ce_n` is 0 and the output is enabled. `data_oe` and an active `ceo_n` are never asserted together.
- R9: After the read has ended, `ceo_n` follows `ce_n` while the output stays enabled. It goes to 1 as soon as the pin leaves the output-enable level. After a reset edge it stays at 1 until the whole array has been read again.
- R10: When `ceo_n` of one device drives `ce_n` of a second device, the two devices together produce one gap-free bitstream, and at most one `data_oe` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst_n | input | 1 | Power-up clear of the position, active low |
| ld_we | input | 1 | Image load strobe |
| ld_addr | input | $clog2(WORDS+1) | Word address to load, 0..WORDS |
| ld_word | input | 32 | Word value to load |
| ce_n | input | 1 | Chip select, active low |
| rst_oe | input | 1 | Shared reset / output-enable pin, polarity from the overflow word |
| data_out | output | 1 | Serial data bit, 0 when not driven |
| data_oe | output | 1 | Data driver enable (models the tri-state) |
| ceo_n | output | 1 | Chain select to the next device, active low |

## Verification
The stream is read in full from a reset, and the bench checks every bit against its own copy of the image. That copy uses words with different patterns, so a fault in bit order, word order or word change shows up as a mismatch. Standby gaps and resets in the middle of the stream are placed at positions that are not word boundaries. This tells apart a frozen position, a cleared position and a position that kept counting. Three overflow values are tried: all zeros, all ones and a mixed value. With these the bench separates the polarity decode from its default. A two-device chain then checks that the handover leaves no lost or doubled bit and that the two drivers never overlap.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int WORD_W = 32;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(WORD_W - 1);

  // overflow word of all zeros selects an active-low reset, all else high
  function automatic logic pol_is_low(input logic [WORD_W-1:0] w);
    return (w == '0);
  endfunction

  // is the shared pin currently at its reset level
  function automatic logic pin_resets(input logic pin, input logic low_pol);
    return low_pol ? ~pin : pin;
  endfunction
endpackage

// File: rtl/sercfg_array.sv
module sercfg_array
  import sercfg_pkg::*;
#(
  parameter int WORDS = 1134,
  localparam int AW = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0] ld_word,
  input  logic [AW-1:0]     rd_word,
  input  logic [BIT_W-1:0]  rd_bit,
  output logic              rd_val,
  output logic              low_pol
);
  localparam logic [AW-1:0] TOP_A = AW'(WORDS);

  // data words 0..WORDS-1, polarity word at WORDS
  logic [WORD_W-1:0] mem [0:WORDS];

  always_ff @(posedge clk) begin
    if (ld_we && ld_addr <= TOP_A) mem[ld_addr] <= ld_word;
  end

  logic [WORD_W-1:0] sel_word;
  assign sel_word = mem[rd_word];
  assign rd_val   = sel_word[rd_bit];
  assign low_pol  = pol_is_low(mem[WORDS]);
endmodule

// File: rtl/sercfg_seq.sv
module sercfg_seq
  import sercfg_pkg::*;
#(
  parameter int WORDS = 1134,
  localparam int AW = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [AW-1:0]    word_q,
  output logic [BIT_W-1:0] bit_q,
  output logic             done_q
);
  localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1);

  logic step;       // a bit is consumed this edge
  logic word_end;   // bit 0 of the current word is being consumed
  assign step     = run && !done_q;
  assign word_end = (bit_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      word_q <= '0;
      bit_q  <= MSB_IDX;
      done_q <= 1'b0;
    end else if (step) begin
      if (word_end) begin
        bit_q <= MSB_IDX;
        if (word_q == LAST_A) done_q <= 1'b1;
        else                  word_q <= word_q + 1'b1;
      end else begin
        bit_q <= bit_q - 1'b1;
      end
    end
  end

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !done_q && bit_q != '0) |=> bit_q == $past(bit_q) - 1'b1);
  // R2
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !done_q && bit_q == '0 && word_q != LAST_A)
      |=> (word_q == $past(word_q) + 1'b1) && (bit_q == MSB_IDX));
  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(word_q) && $stable(bit_q) && $stable(done_q));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (word_q == '0) && (bit_q == MSB_IDX) && !done_q);
  // R8
  end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |=> done_q && $stable(word_q));
endmodule

// File: rtl/sercfg_pin.sv
module sercfg_pin
  import sercfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic rst_oe,
  input  logic low_pol,
  input  logic done,
  input  logic raw_bit,
  output logic clr,
  output logic run,
  output logic data_oe,
  output logic data_out,
  output logic ceo_n
);
  logic oe_act;
  assign clr      = pin_resets(rst_oe, low_pol);
  assign oe_act   = ~clr;
  assign run      = ~ce_n & ~clr;
  assign data_oe  = ~ce_n & oe_act & ~done;
  assign data_out = data_oe & raw_bit;
  assign ceo_n    = ~(done & ~ce_n & oe_act);

  // R3
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !data_oe && ceo_n);
  // R8
  handover_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_oe && !ceo_n));
endmodule

// File: rtl/sercfg_rom.sv
module sercfg_rom
  import sercfg_pkg::*;
#(
  parameter int WORDS = 1134
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_we,
  input  logic [$clog2(WORDS+1)-1:0] ld_addr,
  input  logic [31:0]                ld_word,
  input  logic                       ce_n,
  input  logic                       rst_oe,
  output logic                       data_out,
  output logic                       data_oe,
  output logic                       ceo_n
);
  localparam int AW = $clog2(WORDS + 1);

  logic [AW-1:0]    word_q;
  logic [BIT_W-1:0] bit_q;
  logic             done_q;
  logic             raw_bit;
  logic             low_pol;
  logic             clr;
  logic             run;

  sercfg_array #(.WORDS(WORDS)) u_arr (
    .clk(clk), .ld_we(ld_we), .ld_addr(ld_addr), .ld_word(ld_word),
    .rd_word(word_q), .rd_bit(bit_q), .rd_val(raw_bit), .low_pol(low_pol)
  );

  sercfg_seq #(.WORDS(WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
    .word_q(word_q), .bit_q(bit_q), .done_q(done_q)
  );

  sercfg_pin u_pin (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_oe(rst_oe),
    .low_pol(low_pol), .done(done_q), .raw_bit(raw_bit),
    .clr(clr), .run(run), .data_oe(data_oe), .data_out(data_out),
    .ceo_n(ceo_n)
  );
endmodule

// File: tb/sim_sercfg_rom.sv
module sim_sercfg_rom;
  localparam int W0 = 3;
  localparam int WC = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0, ld_we1 = 1'b0, ld_we2 = 1'b0;
  logic [1:0]  ld_addr = '0;
  logic [31:0] ld_word = '0;
  logic        ce_n = 1'b1, pin = 1'b1;
  logic        d0, oe0, ceo0;
  logic        ce_c = 1'b1, pin_c = 1'b1;
  logic        d1, oe1, ceo1, d2, oe2, ceo2;

  int checks = 0, errors = 0;
  logic [31:0] img0 [0:W0];
  logic [31:0] img1 [0:WC];
  logic [31:0] img2 [0:WC];

  sercfg_rom #(.WORDS(W0)) u0 (.clk(clk), .rst_n(rst_n), .ld_we(ld_we),
    .ld_addr(ld_addr), .ld_word(ld_word), .ce_n(ce_n), .rst_oe(pin),
    .data_out(d0), .data_oe(oe0), .ceo_n(ceo0));
  sercfg_rom #(.WORDS(WC)) u1 (.clk(clk), .rst_n(rst_n), .ld_we(ld_we1),
    .ld_addr(ld_addr), .ld_word(ld_word), .ce_n(ce_c), .rst_oe(pin_c),
    .data_out(d1), .data_oe(oe1), .ceo_n(ceo1));
  sercfg_rom #(.WORDS(WC)) u2 (.clk(clk), .rst_n(rst_n), .ld_we(ld_we2),
    .ld_addr(ld_addr), .ld_word(ld_word), .ce_n(ceo1), .rst_oe(pin_c),
    .data_out(d2), .data_oe(oe2), .ceo_n(ceo2));

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", what, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  function automatic logic bit_of0(input int k);
    return img0[k / 32][31 - (k % 32)];
  endfunction

  task automatic load(input int which, input int a, input logic [31:0] v);
    ld_addr = 2'(a); ld_word = v;
    ld_we = (which == 0); ld_we1 = (which == 1); ld_we2 = (which == 2);
    cyc();
    ld_we = 1'b0; ld_we1 = 1'b0; ld_we2 = 1'b0;
  endtask

  // reset pulse on u0, rlev = reset level of the shared pin
  task automatic pulse0(input logic rlev);
    pin = rlev; cyc(); pin = ~rlev; #1;
  endtask

  task automatic t_stream();
    ce_n = 1'b0; pulse0(1'b1);
    chk("R1 oe after clear", 32'(oe0), 32'd1);
    chk("R1 first bit", 32'(d0), 32'(bit_of0(0)));
    for (int k = 0; k < 32 * W0; k++) begin
      chk($sformatf("R2 bit %0d", k), 32'(d0), 32'(bit_of0(k)));
      chk("R8 chain idle during read", 32'(ceo0), 32'd1);
      cyc();
    end
    #1;
    chk("R8 oe off at end", 32'(oe0), 32'd0);
    chk("R8 ceo low at end", 32'(ceo0), 32'd0);
    cyc(); cyc(); #1;
    chk("R8 hold oe", 32'(oe0), 32'd0);
    chk("R8 hold ceo", 32'(ceo0), 32'd0);
    ce_n = 1'b1; #1;
    chk("R9 ceo follows ce high", 32'(ceo0), 32'd1);
    ce_n = 1'b0; #1;
    chk("R9 ceo follows ce low", 32'(ceo0), 32'd0);
    pin = 1'b1; #1;
    chk("R9 ceo high on oe off", 32'(ceo0), 32'd1);
    chk("R3 oe off at reset level", 32'(oe0), 32'd0);
    cyc(); pin = 1'b0; #1;
    chk("R9 ceo stays high after reset", 32'(ceo0), 32'd1);
    chk("R5 restart bit0", 32'(d0), 32'(bit_of0(0)));
    for (int k = 0; k < 32 * W0 - 1; k++) begin
      cyc();
      if (k == 40) begin #1; chk("R9 ceo high mid reread", 32'(ceo0), 32'd1); end
    end
    cyc(); #1;
    chk("R9 ceo low after reread", 32'(ceo0), 32'd0);
  endtask

  task automatic t_standby();
    ce_n = 1'b0; pulse0(1'b1);
    for (int k = 0; k < 10; k++) cyc();
    ce_n = 1'b1; #1;
    chk("R3 oe off in standby", 32'(oe0), 32'd0);
    chk("R3 data 0 in standby", 32'(d0), 32'd0);
    chk("R3 ceo high in standby", 32'(ceo0), 32'd1);
    for (int k = 0; k < 5; k++) cyc();
    ce_n = 1'b0; #1;
    chk("R4 resume oe", 32'(oe0), 32'd1);
    for (int k = 10; k < 50; k++) begin
      chk($sformatf("R4 resume bit %0d", k), 32'(d0), 32'(bit_of0(k)));
      cyc();
    end
  endtask

  task automatic t_midreset();
    ce_n = 1'b0; pulse0(1'b1);
    for (int k = 0; k < 45; k++) cyc();
    ce_n = 1'b1; pulse0(1'b1); ce_n = 1'b0; #1;
    chk("R5 cleared under standby", 32'(d0), 32'(bit_of0(0)));
    cyc(); #1;
    chk("R5 next after clear", 32'(d0), 32'(bit_of0(1)));
  endtask

  task automatic t_pol_low();
    load(0, W0, 32'h0000_0000);
    ce_n = 1'b0; pin = 1'b0; #1;
    chk("R6 low-pol pin0 disables", 32'(oe0), 32'd0);
    pulse0(1'b0);
    chk("R6 low-pol pin1 enables", 32'(oe0), 32'd1);
    chk("R6 low-pol bit0", 32'(d0), 32'(bit_of0(0)));
    for (int k = 0; k < 5; k++) cyc();
    #1;
    chk("R6 low-pol pin1 counts", 32'(d0), 32'(bit_of0(5)));
    pulse0(1'b0);
    chk("R6 low-pol pin0 clears", 32'(d0), 32'(bit_of0(0)));
    load(0, W0, 32'hFFFF_FFFF);
    ce_n = 1'b0; pin = 1'b0; #1;
    chk("R6 high-pol pin0 enables", 32'(oe0), 32'd1);
  endtask

  task automatic t_pol_other();
    load(0, W0, 32'h0F0F_0000);
    ce_n = 1'b0; pin = 1'b1; #1;
    chk("R7 default pin1 disables", 32'(oe0), 32'd0);
    pulse0(1'b1);
    chk("R7 default pin0 enables", 32'(oe0), 32'd1);
    chk("R7 default bit0", 32'(d0), 32'(bit_of0(0)));
    load(0, W0, 32'hFFFF_FFFF);
  endtask

  task automatic t_chain();
    int n;
    logic e;
    ce_c = 1'b0; pin_c = 1'b1; cyc(); pin_c = 1'b0; #1;
    n = 0;
    for (int k = 0; k < 64 * WC; k++) begin
      e = (k < 32 * WC) ? img1[k / 32][31 - (k % 32)]
                        : img2[(k - 32 * WC) / 32][31 - (k % 32)];
      if (oe1 && oe2) n++;
      chk($sformatf("R10 one driver at %0d", k), 32'(oe1 ^ oe2), 32'd1);
      chk($sformatf("R10 stream bit %0d", k), 32'(d1 | d2), 32'(e));
      cyc();
    end
    #1;
    chk("R10 no overlap seen", 32'(n), 32'd0);
    chk("R10 both idle at end", 32'(oe1 | oe2), 32'd0);
    chk("R10 last ceo low", 32'(ceo2), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    img0[0] = 32'hA5C3_0F81; img0[1] = 32'h1234_5678;
    img0[2] = 32'h8000_0001; img0[3] = 32'hFFFF_FFFF;
    img1[0] = 32'hDEAD_BEEF; img1[1] = 32'h0137_9BDF; img1[2] = 32'hFFFF_FFFF;
    img2[0] = 32'hF0E1_D2C3; img2[1] = 32'h0000_0001; img2[2] = 32'hFFFF_FFFF;
    for (int a = 0; a <= W0; a++) load(0, a, img0[a]);
    for (int a = 0; a <= WC; a++) load(1, a, img1[a]);
    for (int a = 0; a <= WC; a++) load(2, a, img2[a]);
    cyc(); rst_n = 1'b1; cyc();
    // R1 reset state after power-up clear, device selected
    ce_n = 1'b0; pin = 1'b0; #1;
    chk("R1 power-up oe", 32'(oe0), 32'd1);
    chk("R1 power-up bit", 32'(d0), 32'(bit_of0(0)));
    chk("R1 power-up ceo", 32'(ceo0), 32'd1);
    t_stream();
    t_standby();
    t_midreset();
    t_pol_low();
    t_pol_other();
    t_chain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule